// File: doc/BRIEF.md
# Delayed-Write Store Buffer Cache

This block is the front end of a direct-mapped data cache that accepts one load or store per clock and retires store hits at that rate. A store looks up the tags in its request cycle. If it hits, its word address, data and byte mask are parked in a one-entry pending-write register instead of going to the data array. The parked data goes into the array during the tag lookup of the next store, whether that store hits or misses. The data array therefore sees at most one write per cycle, and no store ever needs a second cycle of its own.

A load reads the array in its request cycle. If the load's word address equals the pending entry's address, the pending bytes selected by the held mask are laid over the array word. A miss on either kind of request only raises a flag in the response. A separate fill port writes a whole line and marks it resident. A fill that lands in the set of the pending entry consumes that entry. Responses come out registered, one cycle after the request.

Top module: `dwc_cache`

## Requirements
- R1: While reset is high and on the cycle after it falls, no response is valid and the pending entry is empty. Every line starts invalid, so the first request to any address reports a miss.
- R2: Each request cycle is followed, exactly one cycle later, by a response with `rsp_valid` high. `rsp_hit` is high when the set named by address bits [OFF_W+IDX_W-1:OFF_W] is valid and holds the tag in the upper address bits. `rsp_rdata` carries the word for a load hit and is zero for stores and misses. A cycle with no request gives no response.
- R3: Stores may be issued on consecutive cycles with no stall. Every store hit in such a run is reflected in later loads.
- R4: A store hit enters the pending entry. The entry is written into the data array during the next store's lookup cycle, so that word stays correct after later stores to other addresses.
- R5: A load whose word address equals the pending entry's returns the array word with byte i (bits 8i+7..8i) replaced by the pending data wherever mask bit i is set.
- R6: A store miss changes no cached data and leaves the pending entry empty. An entry that was pending before it is written to the array.
- R7: Loads and idle cycles leave the pending entry and its address untouched.
- R8: A fill writes all words of the line given by `fill_line` (low IDX_W bits select the set, the rest is the tag) and marks the line valid, with word w taken from `fill_data` bits [32w+31:32w]. If the pending entry is in that set, it is cleared. When its tag also matches, its masked bytes are laid over the filled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W (10) | Word address: tag, set, word offset |
| req_wdata | input | DATA_W (32) | Store data |
| req_be | input | BE_W (4) | Store byte mask |
| fill_valid | input | 1 | Line fill this cycle |
| fill_line | input | LINE_AW (8) | Line address: tag above set |
| fill_data | input | LINE_BITS (128) | Whole line, word 0 in the low bits |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_hit | output | 1 | That request hit |
| rsp_rdata | output | DATA_W (32) | Load data, zero otherwise |

## Verification
The assertions rely on the surroundings never presenting a fill and a request in the same cycle. One of them checks that this holds, and the bench's stimulus picks exactly one operation (load, store, fill or idle) per cycle. The properties also assume that a store's lookup result appears unchanged in the following cycle's `rsp_hit`, which holds because no fill can intervene. The bench keeps to a few tags per set so that hits, misses, bypasses and fills that collide with the pending entry all happen often.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

    localparam int DATA_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int BE_W       = DATA_W / BYTE_W;
    localparam int OFF_W      = 2;
    localparam int IDX_W      = 3;
    localparam int TAG_W      = 5;

    localparam int ADDR_W     = TAG_W + IDX_W + OFF_W;
    localparam int LINE_AW    = TAG_W + IDX_W;
    localparam int LINE_WORDS = 1 << OFF_W;
    localparam int SETS       = 1 << IDX_W;
    localparam int LINE_BITS  = DATA_W * LINE_WORDS;

    typedef logic [DATA_W-1:0]    word_t;
    typedef logic [BE_W-1:0]      be_t;
    typedef logic [TAG_W-1:0]     tag_t;
    typedef logic [IDX_W-1:0]     idx_t;
    typedef logic [OFF_W-1:0]     off_t;
    typedef logic [LINE_BITS-1:0] line_t;

    // word address split into its fields, tag on top
    typedef struct packed {
        tag_t tag;
        idx_t idx;
        off_t off;
    } waddr_t;

    // the single deferred store
    typedef struct packed {
        logic   valid;
        waddr_t addr;
        word_t  data;
        be_t    be;
    } pend_t;

    // lay the enabled bytes of upd over base
    function automatic word_t overlay(word_t base, word_t upd, be_t be);
        word_t r;
        r = base;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*BYTE_W +: BYTE_W] = upd[b*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/dwc_tag_store.sv
module dwc_tag_store
    import dwc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  idx_t lk_idx,
    input  tag_t lk_tag,
    output logic lk_hit,
    input  logic fill_en,
    input  idx_t fill_idx,
    input  tag_t fill_tag
);

    logic [SETS-1:0] resident;
    tag_t            tags [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            resident <= '0;
        end else if (fill_en) begin
            resident[fill_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) tags[fill_idx] <= fill_tag;
    end

    assign lk_hit = resident[lk_idx] && (tags[lk_idx] == lk_tag);

endmodule

// File: rtl/dwc_data_store.sv
module dwc_data_store
    import dwc_pkg::*;
(
    input  logic  clk,
    input  idx_t  rd_idx,
    input  off_t  rd_off,
    output word_t rd_word,
    input  logic  wr_word_en,
    input  idx_t  wr_idx,
    input  off_t  wr_off,
    input  word_t wr_data,
    input  be_t   wr_be,
    input  logic  wr_line_en,
    input  idx_t  wr_line_idx,
    input  line_t wr_line_data
);

    word_t mem [SETS][LINE_WORDS];

    // one write port: a whole line from a fill, or one masked word from a drain
    always_ff @(posedge clk) begin
        if (wr_line_en) begin
            for (int w = 0; w < LINE_WORDS; w++) begin
                mem[wr_line_idx][w] <= wr_line_data[w*DATA_W +: DATA_W];
            end
        end else if (wr_word_en) begin
            mem[wr_idx][wr_off] <= overlay(mem[wr_idx][wr_off], wr_data, wr_be);
        end
    end

    assign rd_word = mem[rd_idx][rd_off];

endmodule

// File: rtl/dwc_write_buffer.sv
module dwc_write_buffer
    import dwc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   st_lookup,
    input  logic   st_hit,
    input  waddr_t st_addr,
    input  word_t  st_data,
    input  be_t    st_be,
    input  logic   fill_en,
    input  idx_t   fill_idx,
    input  waddr_t ld_addr,
    input  word_t  arr_word,
    output word_t  ld_word,
    output logic   drain_en,
    output pend_t  pend
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
        end else if (st_lookup) begin
            if (st_hit) begin
                pend.valid <= 1'b1;
                pend.addr  <= st_addr;
                pend.data  <= st_data;
                pend.be    <= st_be;
            end else begin
                pend.valid <= 1'b0;
            end
        end else if (fill_en && pend.valid && (pend.addr.idx == fill_idx)) begin
            pend.valid <= 1'b0;
        end
    end

    // every store lookup cycle retires whatever is parked
    assign drain_en = st_lookup && pend.valid;

    assign ld_word = (pend.valid && (pend.addr == ld_addr))
                   ? overlay(arr_word, pend.data, pend.be)
                   : arr_word;

endmodule

// File: rtl/dwc_cache.sv
module dwc_cache
    import dwc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic                 req_store,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BE_W-1:0]      req_be,
    input  logic                 fill_valid,
    input  logic [LINE_AW-1:0]   fill_line,
    input  logic [LINE_BITS-1:0] fill_data,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [DATA_W-1:0]    rsp_rdata
);

    waddr_t ra;
    idx_t   fill_idx;
    tag_t   fill_tag;
    logic   lk_hit;
    logic   is_load;
    logic   is_store;
    word_t  arr_word;
    word_t  ld_word;
    logic   drain_en;
    pend_t  pend;
    line_t  fill_merged;

    // plain views of the pending entry for the bound checker
    logic   pend_valid;
    idx_t   pend_idx;
    waddr_t pend_addr;

    assign ra       = waddr_t'(req_addr);
    assign fill_idx = fill_line[IDX_W-1:0];
    assign fill_tag = fill_line[LINE_AW-1:IDX_W];
    assign is_load  = req_valid && !req_store;
    assign is_store = req_valid && req_store;

    dwc_tag_store u_tags (
        .clk      (clk),
        .rst      (rst),
        .lk_idx   (ra.idx),
        .lk_tag   (ra.tag),
        .lk_hit   (lk_hit),
        .fill_en  (fill_valid),
        .fill_idx (fill_idx),
        .fill_tag (fill_tag)
    );

    dwc_write_buffer u_wbuf (
        .clk       (clk),
        .rst       (rst),
        .st_lookup (is_store),
        .st_hit    (lk_hit),
        .st_addr   (ra),
        .st_data   (req_wdata),
        .st_be     (req_be),
        .fill_en   (fill_valid),
        .fill_idx  (fill_idx),
        .ld_addr   (ra),
        .arr_word  (arr_word),
        .ld_word   (ld_word),
        .drain_en  (drain_en),
        .pend      (pend)
    );

    // a fill that lands on the parked line keeps the parked bytes
    generate
        for (genvar w = 0; w < LINE_WORDS; w++) begin : g_fill_word
            logic hit_here;
            assign hit_here = pend.valid && (pend.addr.idx == fill_idx)
                           && (pend.addr.tag == fill_tag)
                           && (pend.addr.off == off_t'(w));
            assign fill_merged[w*DATA_W +: DATA_W] = hit_here
                ? overlay(fill_data[w*DATA_W +: DATA_W], pend.data, pend.be)
                : fill_data[w*DATA_W +: DATA_W];
        end
    endgenerate

    dwc_data_store u_data (
        .clk          (clk),
        .rd_idx       (ra.idx),
        .rd_off       (ra.off),
        .rd_word      (arr_word),
        .wr_word_en   (drain_en),
        .wr_idx       (pend.addr.idx),
        .wr_off       (pend.addr.off),
        .wr_data      (pend.data),
        .wr_be        (pend.be),
        .wr_line_en   (fill_valid),
        .wr_line_idx  (fill_idx),
        .wr_line_data (fill_merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_hit   <= req_valid && lk_hit;
            rsp_rdata <= (is_load && lk_hit) ? ld_word : '0;
        end
    end

    assign pend_valid = pend.valid;
    assign pend_idx   = pend.addr.idx;
    assign pend_addr  = pend.addr;

endmodule

// File: rtl/dwc_cache_chk.sv
module dwc_cache_chk
    import dwc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_store,
    input logic               fill_valid,
    input logic [LINE_AW-1:0] fill_line,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [DATA_W-1:0]  rsp_rdata,
    input logic               pend_valid,
    input idx_t               pend_idx,
    input waddr_t             pend_addr
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !pend_valid && !rsp_valid);   // R1

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);   // R2

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);   // R2

    AST_MISS_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> rsp_rdata == '0);   // R2

    AST_PARK_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_store |=> pend_valid == rsp_hit);   // R4

    AST_MISS_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_store |=> !rsp_hit |-> !pend_valid);   // R6

    AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_store && pend_valid |=> pend_valid && $stable(pend_addr));   // R7

    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        !req_valid && !fill_valid |=> $stable(pend_valid));   // R7

    AST_FILL_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        fill_valid && pend_valid && (fill_line[IDX_W-1:0] == pend_idx) |=> !pend_valid);   // R8

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        !(fill_valid && req_valid));   // R8

endmodule

bind dwc_cache dwc_cache_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .fill_valid (fill_valid),
    .fill_line  (fill_line),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_rdata  (rsp_rdata),
    .pend_valid (pend_valid),
    .pend_idx   (pend_idx),
    .pend_addr  (pend_addr)
);

// File: tb/tb_dwc_cache.sv
module tb_dwc_cache;
    import dwc_pkg::*;

    localparam int OP_IDLE  = 0;
    localparam int OP_LOAD  = 1;
    localparam int OP_STORE = 2;
    localparam int OP_FILL  = 3;
    localparam int NWORDS   = 1 << ADDR_W;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 req_valid = 1'b0;
    logic                 req_store = 1'b0;
    logic [ADDR_W-1:0]    req_addr = '0;
    logic [DATA_W-1:0]    req_wdata = '0;
    logic [BE_W-1:0]      req_be = '0;
    logic                 fill_valid = 1'b0;
    logic [LINE_AW-1:0]   fill_line = '0;
    logic [LINE_BITS-1:0] fill_data = '0;
    logic                 rsp_valid;
    logic                 rsp_hit;
    logic [DATA_W-1:0]    rsp_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // behavioural model: what each word reads as when resident
    logic [DATA_W-1:0] refm [NWORDS];
    bit                tv   [SETS];
    int                tg   [SETS];
    bit                pv;
    int                pa;
    logic [DATA_W-1:0] pd;
    logic [BE_W-1:0]   pbe;

    dwc_cache dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .fill_valid(fill_valid), .fill_line(fill_line), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata)
    );

    always #5 clk = ~clk;

    function automatic logic [DATA_W-1:0] bmerge(logic [DATA_W-1:0] o, logic [DATA_W-1:0] n,
                                                 logic [BE_W-1:0] m);
        logic [DATA_W-1:0] r;
        r = o;
        for (int i = 0; i < BE_W; i++) if (m[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    function automatic int mk(int t, int s, int o);
        return (t << (IDX_W + OFF_W)) | (s << OFF_W) | o;
    endfunction

    function automatic logic [LINE_BITS-1:0] line_of_ref(int a);
        logic [LINE_BITS-1:0] f;
        int base;
        base = a & ~(LINE_WORDS - 1);
        for (int w = 0; w < LINE_WORDS; w++) f[w*DATA_W +: DATA_W] = refm[base + w];
        return f;
    endfunction

    // drive one cycle at a falling edge, predict, check at the next falling edge
    task automatic step(input string rq, input int op, input int a,
                        input logic [DATA_W-1:0] d, input logic [BE_W-1:0] m,
                        input logic [LINE_BITS-1:0] fd);
        bit ev, eh;
        logic [DATA_W-1:0] er;
        int ix, tt, base;
        req_valid  = (op == OP_LOAD) || (op == OP_STORE);
        req_store  = (op == OP_STORE);
        req_addr   = a[ADDR_W-1:0];
        req_wdata  = d;
        req_be     = m;
        fill_valid = (op == OP_FILL);
        fill_line  = a[ADDR_W-1:OFF_W];
        fill_data  = fd;
        ix = (a >> OFF_W) % SETS;
        tt = a >> (OFF_W + IDX_W);
        ev = req_valid;
        eh = ev && tv[ix] && (tg[ix] == tt);
        er = (op == OP_LOAD && eh) ? refm[a] : '0;
        if (op == OP_STORE) begin
            if (eh) begin
                refm[a] = bmerge(refm[a], d, m);
                pv = 1; pa = a; pd = d; pbe = m;
            end else begin
                pv = 0;
            end
        end
        if (op == OP_FILL) begin
            tv[ix] = 1;
            tg[ix] = tt;
            base = a & ~(LINE_WORDS - 1);
            for (int w = 0; w < LINE_WORDS; w++) refm[base + w] = fd[w*DATA_W +: DATA_W];
            if (pv && (((pa >> OFF_W) % SETS) == ix)) begin
                if ((pa >> (OFF_W + IDX_W)) == tt) refm[pa] = bmerge(refm[pa], pd, pbe);
                pv = 0;
            end
        end
        @(negedge clk);
        total++;
        if (rsp_valid !== ev || (ev && (rsp_hit !== eh || rsp_rdata !== er))) begin
            bad++;
            $display("FAIL %s addr=%0d op=%0d: valid/hit/rdata got %b/%b/%h exp %b/%b/%h",
                     rq, a, op, rsp_valid, rsp_hit, rsp_rdata, ev, eh, er);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung exp finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [LINE_BITS-1:0] fz;
        for (int i = 0; i < NWORDS; i++) refm[i] = $urandom;
        for (int s = 0; s < SETS; s++) begin tv[s] = 0; tg[s] = 0; end
        pv = 0; pa = 0; pd = '0; pbe = '0;

        // R1: nothing comes out while reset holds
        repeat (3) @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: rsp_valid got %b exp 0", rsp_valid);
        end
        rst = 1'b0;

        // R1: all lines start invalid
        step("R1", OP_LOAD,  mk(0,1,0), '0, '0, '0);
        step("R1", OP_STORE, mk(0,2,0), 32'h1234_5678, 4'hF, '0);
        step("R2", OP_IDLE,  0, '0, '0, '0);

        // R8: fills make lines resident with their data
        step("R8", OP_FILL, mk(0,1,0), '0, '0, line_of_ref(mk(0,1,0)));
        step("R8", OP_FILL, mk(0,2,0), '0, '0, line_of_ref(mk(0,2,0)));
        step("R8", OP_FILL, mk(1,3,0), '0, '0, line_of_ref(mk(1,3,0)));
        step("R8", OP_LOAD, mk(0,1,2), '0, '0, '0);
        step("R2", OP_LOAD, mk(1,1,2), '0, '0, '0);

        // R5: partial store followed at once by a load of the same word
        step("R4", OP_STORE, mk(0,1,1), 32'hAABB_CCDD, 4'b0011, '0);
        step("R5", OP_LOAD,  mk(0,1,1), '0, '0, '0);
        step("R7", OP_LOAD,  mk(0,1,1), '0, '0, '0);
        step("R7", OP_IDLE,  0, '0, '0, '0);
        step("R7", OP_LOAD,  mk(0,1,1), '0, '0, '0);

        // R3: back-to-back stores, then read them all
        step("R3", OP_STORE, mk(0,2,3), 32'h0102_0304, 4'hF, '0);
        step("R3", OP_STORE, mk(0,2,0), 32'h1111_2222, 4'b1010, '0);
        step("R3", OP_STORE, mk(1,3,1), 32'h5555_6666, 4'b0100, '0);
        step("R4", OP_LOAD,  mk(0,1,1), '0, '0, '0);
        step("R3", OP_LOAD,  mk(0,2,3), '0, '0, '0);
        step("R3", OP_LOAD,  mk(0,2,0), '0, '0, '0);
        step("R5", OP_LOAD,  mk(1,3,1), '0, '0, '0);

        // R6: store miss drains the parked store and changes nothing else
        step("R6", OP_STORE, mk(2,1,0), 32'hDEAD_BEEF, 4'hF, '0);
        step("R6", OP_LOAD,  mk(1,3,1), '0, '0, '0);
        step("R6", OP_LOAD,  mk(2,1,0), '0, '0, '0);
        step("R6", OP_LOAD,  mk(0,1,0), '0, '0, '0);

        // R8: stale refill of the parked line keeps the parked bytes
        fz = '0;
        step("R8", OP_STORE, mk(0,1,0), 32'hCAFE_F00D, 4'b1001, '0);
        step("R8", OP_FILL,  mk(0,1,0), '0, '0, fz);
        step("R8", OP_LOAD,  mk(0,1,0), '0, '0, '0);
        step("R8", OP_LOAD,  mk(0,1,1), '0, '0, '0);

        // R8: refill of the set with another tag drops the parked store
        step("R8", OP_STORE, mk(0,2,1), 32'h7777_8888, 4'hF, '0);
        step("R8", OP_FILL,  mk(3,2,0), '0, '0, {4{32'h0BAD_F11E}});
        step("R8", OP_LOAD,  mk(0,2,1), '0, '0, '0);
        step("R8", OP_STORE, mk(3,2,2), 32'h4242_4242, 4'hF, '0);
        step("R8", OP_LOAD,  mk(3,2,1), '0, '0, '0);
        step("R8", OP_LOAD,  mk(3,2,2), '0, '0, '0);

        // mixed traffic over a few tags per set
        for (int n = 0; n < 4000; n++) begin
            int r, a;
            r = $urandom % 100;
            a = mk($urandom % 3, $urandom % SETS, $urandom % LINE_WORDS);
            if (r < 12)      step("R8", OP_FILL,  a, '0, '0, line_of_ref(a));
            else if (r < 55) step("R5", OP_LOAD,  a, '0, '0, '0);
            else if (r < 92) step("R3", OP_STORE, a, $urandom, BE_W'($urandom), '0);
            else             step("R7", OP_IDLE,  a, '0, '0, '0);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule